// File: doc/BRIEF.md
# Operand Bypass and Pipeline Hazard Controller

This block decides, every cycle, where the decode stage of a five-stage in-order pipeline takes its two source operands from, and whether the front of the pipeline moves, holds or is flushed. Operands are bypassed into decode, not into execute. A result that is still in the execute stage or the memory stage can therefore be picked up without waiting for write-back. The block is purely a controller. The datapath muxes, the register file and the program counter logic stay outside it and act on its selects, holds and clears.

Three kinds of events control how instructions move through the pipeline:
- A load in execute whose destination a decode source needs cannot be bypassed. The front end then holds and a bubble enters execute.
- A taken branch resolved in execute redirects fetch and flushes the two younger stages. It wins over a load-use hold.
- A memory-busy request freezes every stage register. A redirect seen while frozen is remembered and is carried out in the first cycle the freeze ends, so the redirect is neither lost nor applied while the stages are held.

Top module: `fwd_stall_ctrl`

## Requirements
- R1: A decode source equal to the execute-stage destination is given select code 1 (execute result) when execute writes a register and does not hold a load. If execute does not write, that stage is not used.
- R2: A decode source that the execute stage does not supply, but that matches a writing memory-stage destination, is given select code 2 (memory result).
- R3: When both the execute and memory stages match a source, the execute stage wins (code 1).
- R4: Register 0 is never bypassed (code 0) and never causes a load-use hold.
- R5: When a load in execute writes a non-zero register read by either decode source, the following happens: the PC hold and the fetch/decode hold are 1, the decode/execute clear is 1, and the decode/execute hold and the fetch/decode clear are 0.
- R6: When memory-busy is low and a redirect is raised, both clears and the redirect-take output are 1 and all holds are 0, even if a load-use hazard is also present.
- R7: While memory-busy is high, all three holds are 1 and both clears and redirect-take are 0, whatever else is raised.
- R8: A redirect raised while memory-busy is high is remembered. In the first cycle memory-busy is low, redirect-take and both clears are 1 even if the redirect input has dropped. One cycle later the remembered request is gone.
- R9: Reset clears the remembered redirect. With idle inputs, all selects are 0 and all controls are 0.
- R10: A source that matches no writing stage is given code 0 (register file).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs1 | input | REG_AW | First decode source register |
| id_rs2 | input | REG_AW | Second decode source register |
| ex_rd | input | REG_AW | Execute-stage destination |
| ex_wen | input | 1 | Execute stage writes a register |
| ex_is_load | input | 1 | Execute stage holds a load |
| mem_rd | input | REG_AW | Memory-stage destination |
| mem_wen | input | 1 | Memory stage writes a register |
| ex_redirect | input | 1 | Branch taken in execute |
| mem_busy | input | 1 | Memory system stall request |
| byp_a | output | 2 | Select for first operand: 0 file, 1 execute, 2 memory |
| byp_b | output | 2 | Select for second operand, same coding |
| hold_pc | output | 1 | Keep PC |
| hold_ifid | output | 1 | Keep fetch/decode register |
| hold_idex | output | 1 | Keep decode/execute register |
| clr_ifid | output | 1 | Flush fetch/decode register |
| clr_idex | output | 1 | Insert bubble into decode/execute |
| take_redirect | output | 1 | Load PC with the branch target now |

## Verification
The checker tests the following on every cycle:
- the freeze under memory-busy;
- the flush on a redirect while not busy;
- the shape of a load-use hold;
- execute-over-memory priority;
- the exclusion of register 0;
- that a redirect seen during a freeze is taken in the next unfrozen cycle.

Only the bench scenarios can show two further things. First, that the remembered redirect fires exactly once after a freeze of several cycles. Second, that reset discards a remembered redirect.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
   typedef enum logic [1:0] {
      SEL_RF  = 2'd0,
      SEL_EX  = 2'd1,
      SEL_MEM = 2'd2
   } byp_sel_e;
endpackage

// File: rtl/fsc_src_sel.sv
module fsc_src_sel
   import fsc_pkg::*;
#(
   parameter int REG_AW = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [REG_AW-1:0] rs,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_wen,
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_wen,
   output byp_sel_e          sel
);
   logic ex_live, mem_live;

   generate
      if (ZERO_HARD) begin : g_zero
         assign ex_live  = ex_wen && (ex_rd != '0);
         assign mem_live = mem_wen && (mem_rd != '0);
      end else begin : g_plain
         assign ex_live  = ex_wen;
         assign mem_live = mem_wen;
      end
   endgenerate

   always_comb begin
      if (ex_live && !ex_is_load && (ex_rd == rs))
         sel = SEL_EX;
      else if (mem_live && (mem_rd == rs))
         sel = SEL_MEM;
      else
         sel = SEL_RF;
   end
endmodule

// File: rtl/fsc_load_use.sv
module fsc_load_use #(
   parameter int REG_AW = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [REG_AW-1:0] id_rs1,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_wen,
   input  logic              ex_is_load,
   output logic              hazard
);
   logic ld_live;

   generate
      if (ZERO_HARD) begin : g_zero
         assign ld_live = ex_is_load && ex_wen && (ex_rd != '0);
      end else begin : g_plain
         assign ld_live = ex_is_load && ex_wen;
      end
   endgenerate

   assign hazard = ld_live && ((ex_rd == id_rs1) || (ex_rd == id_rs2));
endmodule

// File: rtl/fsc_flow.sv
module fsc_flow (
   input  logic clk,
   input  logic rst_n,
   input  logic load_use,
   input  logic ex_redirect,
   input  logic mem_busy,
   output logic hold_pc,
   output logic hold_ifid,
   output logic hold_idex,
   output logic clr_ifid,
   output logic clr_idex,
   output logic take_redirect
);
   logic pend_q;
   logic redir_eff;

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (mem_busy)
         pend_q <= pend_q | ex_redirect;
      else
         pend_q <= 1'b0;
   end

   assign redir_eff = ex_redirect | pend_q;

   always_comb begin
      hold_pc       = 1'b0;
      hold_ifid     = 1'b0;
      hold_idex     = 1'b0;
      clr_ifid      = 1'b0;
      clr_idex      = 1'b0;
      take_redirect = 1'b0;
      if (mem_busy) begin
         hold_pc   = 1'b1;
         hold_ifid = 1'b1;
         hold_idex = 1'b1;
      end else if (redir_eff) begin
         clr_ifid      = 1'b1;
         clr_idex      = 1'b1;
         take_redirect = 1'b1;
      end else if (load_use) begin
         hold_pc   = 1'b1;
         hold_ifid = 1'b1;
         clr_idex  = 1'b1;
      end
   end
endmodule

// File: rtl/fwd_stall_ctrl.sv
module fwd_stall_ctrl
   import fsc_pkg::*;
#(
   parameter int REG_AW = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] id_rs1,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_wen,
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_wen,
   input  logic              ex_redirect,
   input  logic              mem_busy,
   output logic [1:0]        byp_a,
   output logic [1:0]        byp_b,
   output logic              hold_pc,
   output logic              hold_ifid,
   output logic              hold_idex,
   output logic              clr_ifid,
   output logic              clr_idex,
   output logic              take_redirect
);
   localparam int NSRC = 2;

   generate
      if (REG_AW < 2 || REG_AW > 8) begin : g_bad_aw
         $error("fwd_stall_ctrl: REG_AW out of range");
      end
   endgenerate

   logic [REG_AW-1:0] src [NSRC];
   byp_sel_e          sel [NSRC];
   logic              load_use;

   assign src[0] = id_rs1;
   assign src[1] = id_rs2;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         fsc_src_sel #(.REG_AW(REG_AW), .ZERO_HARD(ZERO_HARD)) u_sel (
            .rs         (src[i]),
            .ex_rd      (ex_rd),
            .ex_wen     (ex_wen),
            .ex_is_load (ex_is_load),
            .mem_rd     (mem_rd),
            .mem_wen    (mem_wen),
            .sel        (sel[i])
         );
      end
   endgenerate

   assign byp_a = sel[0];
   assign byp_b = sel[1];

   fsc_load_use #(.REG_AW(REG_AW), .ZERO_HARD(ZERO_HARD)) u_lu (
      .id_rs1     (id_rs1),
      .id_rs2     (id_rs2),
      .ex_rd      (ex_rd),
      .ex_wen     (ex_wen),
      .ex_is_load (ex_is_load),
      .hazard     (load_use)
   );

   fsc_flow u_flow (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_use      (load_use),
      .ex_redirect   (ex_redirect),
      .mem_busy      (mem_busy),
      .hold_pc       (hold_pc),
      .hold_ifid     (hold_ifid),
      .hold_idex     (hold_idex),
      .clr_ifid      (clr_ifid),
      .clr_idex      (clr_idex),
      .take_redirect (take_redirect)
   );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
   parameter int REG_AW = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_AW-1:0] id_rs1,
   input logic [REG_AW-1:0] id_rs2,
   input logic [REG_AW-1:0] ex_rd,
   input logic              ex_wen,
   input logic              ex_is_load,
   input logic              ex_redirect,
   input logic              mem_busy,
   input logic [1:0]        byp_a,
   input logic [1:0]        byp_b,
   input logic              hold_pc,
   input logic              hold_ifid,
   input logic              hold_idex,
   input logic              clr_ifid,
   input logic              clr_idex,
   input logic              take_redirect
);
   assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_busy |-> (hold_pc && hold_ifid && hold_idex && !clr_ifid && !clr_idex && !take_redirect));

   assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_busy && ex_redirect) |-> (clr_ifid && clr_idex && take_redirect && !hold_pc && !hold_ifid));

   assert_loaduse_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_busy && hold_pc) |-> (hold_ifid && clr_idex && !hold_idex && !clr_ifid));

   assert_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mem_busy && ex_redirect) && !mem_busy) |-> take_redirect);

   assert_ex_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_wen && !ex_is_load && ex_rd != '0 && ex_rd == id_rs1) |-> (byp_a == 2'd1));

   assert_code_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_a != 2'd3) && (byp_b != 2'd3));

   generate
      if (ZERO_HARD) begin : g_zero
         assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (id_rs1 == '0) |-> (byp_a == 2'd0));
      end
   endgenerate
endmodule

bind fwd_stall_ctrl fsc_checker #(.REG_AW(REG_AW), .ZERO_HARD(ZERO_HARD)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .id_rs1        (id_rs1),
   .id_rs2        (id_rs2),
   .ex_rd         (ex_rd),
   .ex_wen        (ex_wen),
   .ex_is_load    (ex_is_load),
   .ex_redirect   (ex_redirect),
   .mem_busy      (mem_busy),
   .byp_a         (byp_a),
   .byp_b         (byp_b),
   .hold_pc       (hold_pc),
   .hold_ifid     (hold_ifid),
   .hold_idex     (hold_idex),
   .clr_ifid      (clr_ifid),
   .clr_idex      (clr_idex),
   .take_redirect (take_redirect)
);

// File: tb/sim_fwd_stall_ctrl.sv
module sim_fwd_stall_ctrl;
   localparam int PERIOD = 10;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
   logic          ex_wen = 1'b0, ex_is_load = 1'b0, mem_wen = 1'b0;
   logic          ex_redirect = 1'b0, mem_busy = 1'b0;
   logic [1:0]    byp_a, byp_b;
   logic          hold_pc, hold_ifid, hold_idex, clr_ifid, clr_idex, take_redirect;

   int errors = 0;
   int checks = 0;

   always #(PERIOD/2) clk = ~clk;

   fwd_stall_ctrl #(.REG_AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
      .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
      .mem_rd(mem_rd), .mem_wen(mem_wen), .ex_redirect(ex_redirect),
      .mem_busy(mem_busy), .byp_a(byp_a), .byp_b(byp_b),
      .hold_pc(hold_pc), .hold_ifid(hold_ifid), .hold_idex(hold_idex),
      .clr_ifid(clr_ifid), .clr_idex(clr_idex), .take_redirect(take_redirect)
   );

   // ctl = {hold_pc, hold_ifid, hold_idex, clr_ifid, clr_idex, take_redirect}
   typedef struct packed {
      logic [3:0]    req;
      logic [AW-1:0] rs1, rs2, exrd;
      logic          exw, exl;
      logic [AW-1:0] memrd;
      logic          memw, redir, busy;
      logic [1:0]    ea, eb;
      logic [5:0]    ctl;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{4'd10, 5'd1, 5'd2, 5'd3, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 6'b000000}, // R10
      '{4'd1,  5'd5, 5'd6, 5'd5, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 6'b000000}, // R1
      '{4'd1,  5'd5, 5'd6, 5'd6, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 6'b000000}, // R1
      '{4'd2,  5'd7, 5'd8, 5'd9, 1'b1, 1'b0, 5'd8, 1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 6'b000000}, // R2
      '{4'd3,  5'd7, 5'd7, 5'd7, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1, 6'b000000}, // R3
      '{4'd4,  5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 6'b000000}, // R4
      '{4'd4,  5'd0, 5'd3, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 6'b000000}, // R4
      '{4'd5,  5'd4, 5'd9, 5'd4, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 6'b110010}, // R5
      '{4'd5,  5'd2, 5'd4, 5'd4, 1'b1, 1'b1, 5'd4, 1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 6'b110010}, // R5
      '{4'd1,  5'd5, 5'd5, 5'd5, 1'b0, 1'b0, 5'd5, 1'b1, 1'b0, 1'b0, 2'd2, 2'd2, 6'b000000}, // R1
      '{4'd6,  5'd4, 5'd9, 5'd4, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 6'b000111}, // R6
      '{4'd7,  5'd4, 5'd9, 5'd4, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 6'b111000}, // R7
      '{4'd7,  5'd1, 5'd2, 5'd3, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 6'b111000}  // R7
   };

   function automatic logic [5:0] ctl_now();
      return {hold_pc, hold_ifid, hold_idex, clr_ifid, clr_idex, take_redirect};
   endfunction

   task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic idle();
      id_rs1 = '0; id_rs2 = '0; ex_rd = '0; mem_rd = '0;
      ex_wen = 0; ex_is_load = 0; mem_wen = 0; ex_redirect = 0; mem_busy = 0;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   initial begin
      #(PERIOD * 5000);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle();
      step(); step();
      #2;
      // R9: outputs idle while in reset
      check("R9", {byp_a, byp_b, ctl_now()}, 10'b0);
      step();
      rst_n = 1'b1;
      step();

      for (int i = 0; i < NV; i++) begin
         id_rs1 = VEC[i].rs1; id_rs2 = VEC[i].rs2; ex_rd = VEC[i].exrd;
         ex_wen = VEC[i].exw; ex_is_load = VEC[i].exl; mem_rd = VEC[i].memrd;
         mem_wen = VEC[i].memw; ex_redirect = VEC[i].redir; mem_busy = VEC[i].busy;
         #2;
         check($sformatf("R%0d vec%0d", VEC[i].req, i), {byp_a, byp_b, ctl_now()},
               {VEC[i].ea, VEC[i].eb, VEC[i].ctl});
         step();
      end

      // R8: redirect during a three-cycle freeze, dropped before it ends
      idle(); mem_busy = 1; ex_redirect = 1;
      #2 check("R8 frozen", {2'b0, 2'b0, ctl_now()}, {4'b0, 6'b111000});
      step(); ex_redirect = 0;
      #2 check("R8 still frozen", {4'b0, ctl_now()}, {4'b0, 6'b111000});
      step();
      step(); mem_busy = 0;
      #2 check("R8 release take", {4'b0, ctl_now()}, {4'b0, 6'b000111});
      step();
      #2 check("R8 taken once", {4'b0, ctl_now()}, 10'b0);
      // R8: remembered redirect beats a load-use hazard on release
      mem_busy = 1; ex_redirect = 1;
      step(); ex_redirect = 0; mem_busy = 0;
      ex_rd = 5'd6; ex_wen = 1; ex_is_load = 1; id_rs1 = 5'd6;
      #2 check("R8 over load-use", {4'b0, ctl_now()}, {4'b0, 6'b000111});
      step();
      #2 check("R5 after release", {4'b0, ctl_now()}, {4'b0, 6'b110010});
      idle();

      // R9: reset discards a remembered redirect
      mem_busy = 1; ex_redirect = 1;
      step(); rst_n = 0; ex_redirect = 0; mem_busy = 0;
      step(); rst_n = 1;
      #2 check("R9 pending cleared", {byp_a, byp_b, ctl_now()}, 10'b0);
      step();

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule